// File: doc/BRIEF.md
# Temperature Conversion Rate Scheduler

This block paces an external temperature converter. It holds two configuration fields, a 4-bit rate code and a 2-bit channel selector. From these it decides when a conversion begins and which sensing channel the conversion uses. Each launch is a one-cycle `conv_start` pulse with a channel index on `conv_chan`. The block then waits for the converter to answer on `conv_done` before it launches again.

Pacing comes from `tick`, a base pulse that arrives 32 times per second. Rate codes 0 to 9 give one scheduling period every 2^(9-code) ticks, which is 1/16 up to 32 periods per second. Every higher code makes the block run continuously: a new conversion begins as soon as the previous one ends.

In fixed-channel modes a period produces one conversion. In round-robin mode a period produces three conversions back to back, one per channel. A request that arrives while work is still in progress is kept as a single pending request.

Top module: `tconv_sched`

## Requirements
- R1: After reset, `conv_start` is low. The rate field is 1000, so a period completes on every second tick. The selector is 00, which is round robin.
- R2: For rate code n from 0 to 9, a period completes on every 2^(9-n)-th tick. Ticks are counted from reset or from the last configuration write. `conv_start` rises in the cycle after the tick that completes a period.
- R3: Rate codes 1010 through 1111 select continuous mode, where ticks are not needed. After `conv_done` is presented for one cycle, the next `conv_start` appears two cycles later.
- R4: `conv_start` is a single-cycle pulse. It is never raised between a start and the `conv_done` that answers it.
- R5: Selector 01 measures channel 0 (local), selector 10 measures channel 1 (core 1) and selector 11 measures channel 2 (core 2). In these modes each period launches one conversion.
- R6: Selector 00 (round robin) launches three conversions per period, on channels 0, 1 and 2 in that order. Each one starts after the previous one is done.
- R7: Period requests that arrive while work is in progress collapse into one pending request. That request is served once the work finishes.
- R8: A configuration write restarts the tick count. It also returns the round-robin pointer to channel 0, and it discards any pending or partly served request.
- R9: A `conv_done` pulse while no conversion is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | One-cycle write strobe for both configuration fields |
| cfg_rate | input | 4 | Rate code to be written |
| cfg_sel | input | 2 | Channel selector to be written |
| tick | input | 1 | Base time pulse, 32 per second, one cycle wide |
| conv_done | input | 1 | Converter reports that the running conversion has finished |
| conv_start | output | 1 | One-cycle pulse that launches a conversion |
| conv_chan | output | 2 | Channel for the launched conversion (0 local, 1 core 1, 2 core 2) |

## Verification
The hardest case to reach is a configuration write that lands in the middle of a round-robin sequence while a conversion is still outstanding. Only a correct write restores channel 0 on the next launch.

The bench reaches this case by turning off its automatic converter model and answering `conv_done` by hand. It runs continuous round robin until channel 1 is in flight, writes a new configuration, and only then releases the converter.

Collapsing of pending requests is driven in a similar way. A slow converter model keeps one conversion busy across several ticks.

// File: rtl/tconv_pkg.sv
// Package: shared constants and types for the conversion rate scheduler.
// Assumes the selector code 00 means round robin and the others pick a fixed channel.
package tconv_pkg;

    localparam int RATE_W    = 4;
    localparam int SEL_W     = 2;
    localparam int CHAN_W    = 2;
    localparam int NUM_CH    = 3;
    localparam int TOP_CODE  = 9;
    localparam logic [RATE_W-1:0] RATE_DEFAULT = 4'b1000;

    typedef enum logic [SEL_W-1:0] {
        SEL_ROUND  = 2'b00,
        SEL_LOCAL  = 2'b01,
        SEL_CORE_A = 2'b10,
        SEL_CORE_B = 2'b11
    } sel_mode_e;

endpackage

// File: rtl/tconv_rate_div.sv
// Module: counts base ticks and flags the tick that closes a scheduling period.
// Assumes rate codes above TOP_CODE mean continuous mode, which raises no period flags.
// Assumes 'restart' clears the count, and that the rate only changes together with a restart.
module tconv_rate_div #(
    parameter int RATE_W   = 4,
    parameter int TOP_CODE = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    output logic              period_hit,
    output logic              cont
);

    localparam int CNT_W = TOP_CODE;
    localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last;
    logic [RATE_W-1:0] shamt;

    // Derive the final count of a period from the rate code.
    always_comb begin
        cont  = rate > RATE_W'(TOP_CODE);
        shamt = RATE_W'(TOP_CODE) - rate;
        last  = ~(ONES << shamt);
    end

    // Flag the tick that closes a period, unless a write restarts the count.
    assign period_hit = tick && !cont && !restart && (cnt == last);

    // Advance the tick count within the period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (tick && !cont) begin
            cnt <= (cnt == last) ? '0 : cnt + CNT_W'(1);
        end
    end

    a_r2_cnt_in_span: assert property (@(posedge clk) disable iff (!rst_n)
        !cont |-> cnt <= last);

endmodule

// File: rtl/tconv_chan_seq.sv
// Module: chooses the channel for the next launch.
// Assumes 'advance' pulses once per launch. In round robin, the pointer steps 0, 1, 2 and wraps.
module tconv_chan_seq #(
    parameter int SEL_W  = 2,
    parameter int CHAN_W = 2,
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    input  logic              rr,
    input  logic [SEL_W-1:0]  sel,
    output logic [CHAN_W-1:0] chan
);

    logic [CHAN_W-1:0] ptr;

    // Fixed modes map selector 1..3 onto channel 0..2.
    assign chan = rr ? ptr : CHAN_W'(sel - SEL_W'(1));

    // Step the round-robin pointer after each launch; a write returns it to channel 0.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ptr <= '0;
        end else if (advance && rr) begin
            ptr <= (ptr == CHAN_W'(NUM_CH - 1)) ? '0 : ptr + CHAN_W'(1);
        end
    end

    a_r6_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr < CHAN_W'(NUM_CH));

endmodule

// File: rtl/tconv_start_ctl.sv
// Module: issues launches, tracks the outstanding conversion, serves period requests.
// Assumes one conversion at a time. A round-robin period holds NUM_CH launches.
// A request arriving while work is in progress is kept as one pending flag.
module tconv_start_ctl #(
    parameter int CHAN_W = 2,
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              req,
    input  logic              cont,
    input  logic              rr,
    input  logic              done,
    input  logic [CHAN_W-1:0] chan_in,
    output logic              launch,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan
);

    localparam int LEFT_W = $clog2(NUM_CH);

    logic              busy;
    logic              pend;
    logic [LEFT_W-1:0] left;
    logic              burst_open;
    logic              consume;

    // Decide whether a launch happens at this edge.
    always_comb begin
        burst_open = (left != '0);
        launch     = !busy && !restart && (cont || burst_open || pend || req);
        consume    = launch && !cont && !burst_open;
    end

    // Register the launch pulse and its channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start <= 1'b0;
            conv_chan  <= '0;
        end else begin
            conv_start <= launch;
            if (launch) begin
                conv_chan <= chan_in;
            end
        end
    end

    // Track the outstanding conversion; a done with nothing outstanding is ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (launch) begin
            busy <= 1'b1;
        end else if (done) begin
            busy <= 1'b0;
        end
    end

    // Count the launches still owed within the current period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            left <= '0;
        end else if (launch && !cont) begin
            left <= burst_open ? left - LEFT_W'(1)
                               : (rr ? LEFT_W'(NUM_CH - 1) : '0);
        end
    end

    // Keep at most one request that could not be served at once.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || cont) begin
            pend <= 1'b0;
        end else if (consume) begin
            pend <= pend && req;
        end else if (req) begin
            pend <= 1'b1;
        end
    end

    a_r4_start_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    a_r4_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !$past(busy));

    a_r5_chan_legal: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> conv_chan < CHAN_W'(NUM_CH));

endmodule

// File: rtl/tconv_sched.sv
// Module: top of the conversion rate scheduler. Holds the rate and selector fields
// and connects the tick divider, the channel sequencer and the launch control.
// Assumes cfg_wr writes both fields at once, and that every write restarts the scheduling.
module tconv_sched
    import tconv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              tick,
    input  logic              conv_done,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan
);

    logic [RATE_W-1:0] rate_q;
    sel_mode_e         sel_q;
    logic              period_hit;
    logic              cont;
    logic              rr;
    logic              launch;
    logic [CHAN_W-1:0] next_chan;

    // Hold the configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= RATE_DEFAULT;
            sel_q  <= SEL_ROUND;
        end else if (cfg_wr) begin
            rate_q <= cfg_rate;
            sel_q  <= sel_mode_e'(cfg_sel);
        end
    end

    assign rr = (sel_q == SEL_ROUND);

    tconv_rate_div #(
        .RATE_W   (RATE_W),
        .TOP_CODE (TOP_CODE)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (cfg_wr),
        .tick       (tick),
        .rate       (rate_q),
        .period_hit (period_hit),
        .cont       (cont)
    );

    tconv_chan_seq #(
        .SEL_W  (SEL_W),
        .CHAN_W (CHAN_W),
        .NUM_CH (NUM_CH)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_wr),
        .advance (launch),
        .rr      (rr),
        .sel     (sel_q),
        .chan    (next_chan)
    );

    tconv_start_ctl #(
        .CHAN_W (CHAN_W),
        .NUM_CH (NUM_CH)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (cfg_wr),
        .req        (period_hit),
        .cont       (cont),
        .rr         (rr),
        .done       (conv_done),
        .chan_in    (next_chan),
        .launch     (launch),
        .conv_start (conv_start),
        .conv_chan  (conv_chan)
    );

endmodule

// File: tb/tconv_sched_tb.sv
// Directed bench: one task per scenario. A converter model answers launches after 'lat' cycles.
module tconv_sched_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_rate = 4'd0;
    logic [1:0] cfg_sel = 2'd0;
    logic       tick = 1'b0;
    logic       conv_done = 1'b0;
    logic       conv_start;
    logic [1:0] conv_chan;

    int checks = 0;
    int errors = 0;
    int start_cnt = 0;
    int tick_num = 0;
    int cyc = 0;
    int lat = 2;
    int timer = 0;
    int viol = 0;
    bit auto_en = 1'b1;
    bit man_done = 1'b0;
    bit outstanding = 1'b0;
    int chan_log[16];
    int tick_log[16];
    int cyc_log[16];

    tconv_sched u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_rate   (cfg_rate),
        .cfg_sel    (cfg_sel),
        .tick       (tick),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .conv_chan  (conv_chan)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor launches, then drive the converter model's done.
    always @(negedge clk) begin
        cyc++;
        if (conv_done) outstanding = 1'b0;
        if (rst_n && conv_start) begin
            if (outstanding) viol++;
            outstanding = 1'b1;
            if (start_cnt < 16) begin
                chan_log[start_cnt] = int'(conv_chan);
                tick_log[start_cnt] = tick_num;
                cyc_log[start_cnt]  = cyc;
            end
            start_cnt++;
        end
        conv_done = 1'b0;
        if (man_done) begin
            conv_done = 1'b1;
            man_done  = 1'b0;
        end else if (auto_en) begin
            if (rst_n && conv_start) begin
                timer = lat;
            end else if (timer > 0) begin
                timer--;
                if (timer == 0) conv_done = 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_ticks(input int n, input int gap);
        repeat (n) begin
            @(negedge clk);
            tick = 1'b1;
            tick_num++;
            @(negedge clk);
            tick = 1'b0;
            repeat (gap - 2) @(negedge clk);
        end
    endtask

    task automatic write_cfg(input logic [3:0] r, input logic [1:0] s);
        @(negedge clk);
        cfg_rate = r;
        cfg_sel  = s;
        cfg_wr   = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic clear_logs();
        @(posedge clk);
        start_cnt = 0;
        tick_num  = 0;
    endtask

    task automatic pulse_done();
        @(posedge clk);
        man_done = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    // R1: reset state and default round robin every second tick.
    task automatic t_reset_defaults();
        check(conv_start == 1'b0, "R1 start low after reset", int'(conv_start), 0);
        clear_logs();
        lat = 2;
        send_ticks(4, 20);
        wait_cyc(10);
        check(start_cnt == 6, "R1 launches in two default periods", start_cnt, 6);
        check(tick_log[0] == 2, "R1 first period on tick 2", tick_log[0], 2);
        check(tick_log[3] == 4, "R1 second period on tick 4", tick_log[3], 4);
        for (int i = 0; i < 6; i++)
            check(chan_log[i] == i % 3, "R6 round robin order", chan_log[i], i % 3);
    endtask

    // R2: period length for several rate codes in a fixed mode.
    task automatic t_rate_sweep();
        int codes[4] = '{9, 6, 3, 0};
        for (int k = 0; k < 4; k++) begin
            int p;
            p = 1 << (9 - codes[k]);
            write_cfg(4'(codes[k]), 2'b01);
            clear_logs();
            send_ticks(2 * p, 6);
            wait_cyc(10);
            check(start_cnt == 2, "R2 one launch per period", start_cnt, 2);
            check(tick_log[0] == p, "R2 first period tick", tick_log[0], p);
            check(tick_log[1] == 2 * p, "R2 second period tick", tick_log[1], 2 * p);
        end
    endtask

    // R5: fixed channels for selectors 10 and 11.
    task automatic t_fixed_channels();
        for (int s = 2; s < 4; s++) begin
            write_cfg(4'd9, 2'(s));
            clear_logs();
            send_ticks(3, 8);
            wait_cyc(8);
            check(start_cnt == 3, "R5 one launch per tick at code 9", start_cnt, 3);
            for (int i = 0; i < 3; i++)
                check(chan_log[i] == s - 1, "R5 fixed channel", chan_log[i], s - 1);
        end
    endtask

    // R3: continuous modes, both an unused code (RR) and code 1010 (fixed).
    task automatic t_continuous();
        lat = 3;
        clear_logs();
        write_cfg(4'd15, 2'b00);
        wait_cyc(40);
        check(start_cnt >= 6, "R3 continuous launches without ticks", start_cnt, 6);
        for (int i = 0; i < 4; i++)
            check(chan_log[i] == i % 3, "R3 continuous round robin order", chan_log[i], i % 3);
        check(cyc_log[2] - cyc_log[1] == lat + 2, "R3 relaunch gap", cyc_log[2] - cyc_log[1], lat + 2);
        write_cfg(4'd9, 2'b01);
        wait_cyc(20);
        clear_logs();
        write_cfg(4'd10, 2'b01);
        wait_cyc(30);
        check(start_cnt >= 4, "R3 code 1010 continuous", start_cnt, 4);
        check(chan_log[1] == 0, "R3 continuous fixed channel", chan_log[1], 0);
        check(cyc_log[2] - cyc_log[1] == lat + 2, "R3 relaunch gap code 1010",
              cyc_log[2] - cyc_log[1], lat + 2);
        write_cfg(4'd9, 2'b01);
        wait_cyc(20);
        lat = 2;
    endtask

    // R7: ticks during a long conversion collapse into one pending request.
    task automatic t_pending();
        lat = 60;
        write_cfg(4'd9, 2'b01);
        clear_logs();
        send_ticks(4, 10);
        wait_cyc(150);
        check(start_cnt == 2, "R7 extra ticks collapse to one", start_cnt, 2);
        check(tick_log[1] == 4, "R7 pending served after done", tick_log[1], 4);
        lat = 2;
        send_ticks(1, 10);
        wait_cyc(10);
        check(start_cnt == 3, "R7 pending cleared once served", start_cnt, 3);
    endtask

    // R8: a write restarts the tick count and returns the pointer to channel 0.
    task automatic t_restart();
        write_cfg(4'd8, 2'b01);
        clear_logs();
        send_ticks(1, 6);
        write_cfg(4'd8, 2'b01);
        send_ticks(1, 6);
        check(start_cnt == 0, "R8 count restarted by write", start_cnt, 0);
        send_ticks(1, 6);
        wait_cyc(4);
        check(start_cnt == 1, "R8 period after restart", start_cnt, 1);
        auto_en = 1'b0;
        timer = 0;
        wait_cyc(4);
        clear_logs();
        write_cfg(4'd15, 2'b00);
        wait_cyc(4);
        pulse_done();
        wait_cyc(4);
        check(start_cnt == 2 && chan_log[1] == 1, "R8 core 1 in flight", chan_log[1], 1);
        write_cfg(4'd9, 2'b00);
        pulse_done();
        wait_cyc(4);
        check(start_cnt == 2, "R8 no launch without tick", start_cnt, 2);
        send_ticks(1, 4);
        check(chan_log[2] == 0, "R8 pointer back to local", chan_log[2], 0);
        pulse_done();
        wait_cyc(3);
        pulse_done();
        wait_cyc(3);
        pulse_done();
        auto_en = 1'b1;
    endtask

    // R9: a done with nothing outstanding changes nothing.
    task automatic t_stray_done();
        auto_en = 1'b0;
        write_cfg(4'd9, 2'b01);
        clear_logs();
        pulse_done();
        pulse_done();
        wait_cyc(5);
        check(start_cnt == 0, "R9 stray done launches nothing", start_cnt, 0);
        send_ticks(1, 4);
        check(start_cnt == 1, "R9 tick still launches", start_cnt, 1);
        pulse_done();
        send_ticks(1, 4);
        check(start_cnt == 2, "R9 normal service continues", start_cnt, 2);
        pulse_done();
        auto_en = 1'b1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual %0d expected %0d", WATCHDOG, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset_defaults();
        t_rate_sweep();
        t_fixed_channels();
        t_continuous();
        t_pending();
        t_restart();
        t_stray_done();
        check(viol == 0, "R4 no launch while outstanding", viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule